// File: doc/BRIEF.md
# Grouped Trigger Inhibit Register Bank

This block holds the per-trigger inhibit lines and the single inhibit-all line that a trigger decision unit obeys at all times. Software reaches it over a simple 16-bit register port made of an address, a write strobe and write data, with read data returned combinationally for the address presented. Board routing only lets four inhibit lines be steered from one register, so the 64 lines are spread across 16 registers placed at separate, non-adjacent word addresses; only the low four bits of each register reach the lines, while its remaining bits are kept and returned on read.

A further register carries the inhibit-all bit in its lowest position. From both sources the block derives one permit qualifier per trigger, high only when neither that trigger's own inhibit nor the inhibit-all line is set. Writes take effect at the clock edge that accepts them; the lines are not aligned to any outside timing. After reset every line is inhibited, so nothing may fire until software clears them.

Top module: `trig_inhibit_regs`

## Requirements
- R1: Group register k (k = 0..15) lives at word address BASE_ADDR + k*ADDR_STRIDE (default 0x10 + 2k), and its bit j (j = 0..3) drives inhibit_o[4k+j].
- R2: A write to group register k changes inhibit_o[4k+3:4k] to the written low nibble from the cycle after the accepting clock edge, and leaves every other group's lines unchanged.
- R3: Bits 15:4 of a group register are stored and read back exactly as written, and have no effect on any output.
- R4: In a cycle with bus_wr low, bus_rdata equals the full 16-bit value held by the register selected by bus_addr in that same cycle.
- R5: The inhibit-all register sits at GLOBAL_ADDR (default 0x40); its bit 0 drives global_inhibit_o and bits 15:1 are stored and read back without effect.
- R6: fire_ok_o[i] is 1 exactly when inhibit_o[i] is 0 and global_inhibit_o is 0.
- R7: After reset every group register reads 0x000F, the inhibit-all register reads 0x0001, all inhibit_o bits and global_inhibit_o are 1 and every fire_ok_o bit is 0.
- R8: A read at an address holding no register returns 0x0000, and a write there changes no output and no register.
- R9: While bus_wr is low, inhibit_o, global_inhibit_o and the contents of every register stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| inhibit_o | output | 64 | Per-trigger inhibit lines, 1 = inhibited |
| global_inhibit_o | output | 1 | Inhibit-all line, 1 = all inhibited |
| fire_ok_o | output | 64 | Per-trigger permit qualifier |

## Verification
The bench builds the block with its default parameters: sixteen four-line groups, base address 0x10, a stride of two and the inhibit-all register at 0x40. The stride of two leaves an unmapped odd address between every pair of group registers, so reads and writes that fall inside the span of the map but hit no register are within reach, alongside addresses beyond it. The 8-bit address space is small enough to be swept completely, so the reset image and the zero returned for every empty address are checked at all 256 addresses, and random writes then mix mapped and unmapped targets with random data in the upper register bits.

// File: rtl/trig_inhibit_pkg.sv
// Package: trig_inhibit_pkg
// Shared helpers for the grouped trigger inhibit register bank.
// Assumes addresses fit in 32 bits.
package trig_inhibit_pkg;

    // Word address of group register k in the bank.
    function automatic int unsigned slot_addr(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned k);
        return base + k * stride;
    endfunction

    // Reset image of a group register: all lanes inhibited.
    function automatic int unsigned lane_mask(input int unsigned lanes);
        return (32'd1 << lanes) - 32'd1;
    endfunction

endpackage

// File: rtl/tir_word_reg.sv
// Module: tir_word_reg
// One 16-bit read/write register that loads bus data when the write strobe
// is high and the bus address equals MY_ADDR. Assumes one write per cycle.
module tir_word_reg #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MY_ADDR   = 0,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam logic [ADDR_W-1:0] SEL  = ADDR_W'(MY_ADDR);
    localparam logic [DATA_W-1:0] INIT = DATA_W'(RESET_VAL);

    logic hit;

    // Address match for this register.
    always_comb begin
        hit = wr && (addr == SEL);
    end

    // Storage: reset to INIT, load the whole word on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (hit) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/tir_read_mux.sv
// Module: tir_read_mux
// Combinational read port: returns the word of the register mapped at addr,
// or zero where no register is mapped. Assumes the global address does not
// collide with any group address.
module tir_read_mux
    import trig_inhibit_pkg::*;
#(
    parameter int unsigned N_GROUPS    = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_ADDR   = 16,
    parameter int unsigned ADDR_STRIDE = 2,
    parameter int unsigned GLOBAL_ADDR = 64
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [N_GROUPS-1:0][DATA_W-1:0]  grp_words,
    input  logic [DATA_W-1:0]                glb_word,
    output logic [DATA_W-1:0]                rdata
);
    localparam logic [ADDR_W-1:0] GSEL = ADDR_W'(GLOBAL_ADDR);

    logic [N_GROUPS-1:0][DATA_W-1:0] gated;

    // Per-group gating: each slot contributes its word only when selected.
    for (genvar k = 0; k < N_GROUPS; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] KSEL =
            ADDR_W'(slot_addr(BASE_ADDR, ADDR_STRIDE, k));
        always_comb begin
            gated[k] = (addr == KSEL) ? grp_words[k] : '0;
        end
    end

    // OR-combine the gated words with the global register slot.
    always_comb begin
        rdata = (addr == GSEL) ? glb_word : '0;
        for (int k = 0; k < N_GROUPS; k++) begin
            rdata = rdata | gated[k];
        end
    end
endmodule

// File: rtl/tir_qualifier.sv
// Module: tir_qualifier
// Derives one permit bit per trigger: set only when neither the trigger's
// own inhibit nor the inhibit-all line is active.
module tir_qualifier #(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] inh,
    input  logic             glb,
    output logic [WIDTH-1:0] fire_ok
);
    // Permit combination per trigger line.
    always_comb begin
        fire_ok = ~inh & {WIDTH{~glb}};
    end
endmodule

// File: rtl/trig_inhibit_regs.sv
// Module: trig_inhibit_regs
// Bank of grouped trigger inhibit registers plus an inhibit-all register.
// Group register k drives inhibit lanes LANES*k .. LANES*k+LANES-1 from its
// low bits; upper bits are stored only. Assumes LANES <= DATA_W, mapped
// addresses are distinct, and writes are single-cycle strobes.
module trig_inhibit_regs
    import trig_inhibit_pkg::*;
#(
    parameter int unsigned N_GROUPS    = 16,
    parameter int unsigned LANES       = 4,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_ADDR   = 16,
    parameter int unsigned ADDR_STRIDE = 2,
    parameter int unsigned GLOBAL_ADDR = 64,
    localparam int unsigned OUT_W      = N_GROUPS * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [OUT_W-1:0]  inhibit_o,
    output logic              global_inhibit_o,
    output logic [OUT_W-1:0]  fire_ok_o
);
    localparam int unsigned GRP_INIT = lane_mask(LANES);

    logic [N_GROUPS-1:0][DATA_W-1:0] grp_words;
    logic [DATA_W-1:0]               glb_word;

    // One register per group, each at its own computed address.
    for (genvar k = 0; k < N_GROUPS; k++) begin : g_grp
        tir_word_reg #(
            .DATA_W   (DATA_W),
            .ADDR_W   (ADDR_W),
            .MY_ADDR  (slot_addr(BASE_ADDR, ADDR_STRIDE, k)),
            .RESET_VAL(GRP_INIT)
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (bus_addr),
            .wr   (bus_wr),
            .wdata(bus_wdata),
            .q    (grp_words[k])
        );

        // Lane fan-out: only the low LANES bits reach the inhibit lines.
        always_comb begin
            inhibit_o[k*LANES +: LANES] = grp_words[k][LANES-1:0];
        end
    end

    // Inhibit-all register; bit 0 is the only functional bit.
    tir_word_reg #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .MY_ADDR  (GLOBAL_ADDR),
        .RESET_VAL(1)
    ) u_glb (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .q    (glb_word)
    );

    // Global line taken from bit 0 of the inhibit-all register.
    always_comb begin
        global_inhibit_o = glb_word[0];
    end

    tir_read_mux #(
        .N_GROUPS   (N_GROUPS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .ADDR_STRIDE(ADDR_STRIDE),
        .GLOBAL_ADDR(GLOBAL_ADDR)
    ) u_rd (
        .addr     (bus_addr),
        .grp_words(grp_words),
        .glb_word (glb_word),
        .rdata    (bus_rdata)
    );

    tir_qualifier #(
        .WIDTH(OUT_W)
    ) u_q (
        .inh    (inhibit_o),
        .glb    (global_inhibit_o),
        .fire_ok(fire_ok_o)
    );
endmodule

// File: rtl/trig_inhibit_regs_chk.sv
// Module: trig_inhibit_regs_chk
// Port-level checker for trig_inhibit_regs, attached by bind below.
// Assumes the same parameter values as the bound instance.
module trig_inhibit_regs_chk
    import trig_inhibit_pkg::*;
#(
    parameter int unsigned N_GROUPS    = 16,
    parameter int unsigned LANES       = 4,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_ADDR   = 16,
    parameter int unsigned ADDR_STRIDE = 2,
    parameter int unsigned GLOBAL_ADDR = 64,
    localparam int unsigned OUT_W      = N_GROUPS * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [OUT_W-1:0]  inhibit_o,
    input logic              global_inhibit_o,
    input logic [OUT_W-1:0]  fire_ok_o
);
    localparam logic [ADDR_W-1:0] GSEL = ADDR_W'(GLOBAL_ADDR);

    logic [N_GROUPS-1:0] slot_hit;
    logic                mapped;

    // Decode of mapped addresses, kept independent of the design's mux.
    always_comb begin
        for (int k = 0; k < N_GROUPS; k++) begin
            slot_hit[k] = (bus_addr ==
                           ADDR_W'(slot_addr(BASE_ADDR, ADDR_STRIDE, k)));
        end
        mapped = (|slot_hit) || (bus_addr == GSEL);
    end

    // R2: a write to group k lands in exactly its lanes one cycle later.
    for (genvar k = 0; k < N_GROUPS; k++) begin : g_chk
        a_r2_group_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && slot_hit[k]) |=>
                (inhibit_o[k*LANES +: LANES] == $past(bus_wdata[LANES-1:0])))
            else $error("a_r2_group_write");
    end

    // R5: inhibit-all line follows bit 0 of the last write to its register.
    a_r5_global_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == GSEL) |=> (global_inhibit_o == $past(bus_wdata[0])))
        else $error("a_r5_global_write");

    // R6: permit only when neither inhibit is active.
    a_r6_fire_rule: assert property (@(posedge clk) disable iff (!rst_n)
        global_inhibit_o |-> (fire_ok_o == '0))
        else $error("a_r6_fire_rule");

    a_r6_no_permit_when_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_ok_o & inhibit_o) == '0))
        else $error("a_r6_no_permit_when_inhibited");

    // R4: reading the global slot returns the live line in bit 0.
    a_r4_global_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && bus_addr == GSEL) |-> (bus_rdata[0] == global_inhibit_o))
        else $error("a_r4_global_readback");

    // R8: unmapped addresses read as zero.
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0))
        else $error("a_r8_unmapped_zero");

    // R9: no write, no change on the lines.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(inhibit_o) && $stable(global_inhibit_o)))
        else $error("a_r9_hold");

    // R8: a write to an unmapped address leaves the lines alone.
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(inhibit_o) && $stable(global_inhibit_o)))
        else $error("a_r8_unmapped_write");
endmodule

bind trig_inhibit_regs trig_inhibit_regs_chk #(
    .N_GROUPS   (N_GROUPS),
    .LANES      (LANES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .ADDR_STRIDE(ADDR_STRIDE),
    .GLOBAL_ADDR(GLOBAL_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .inhibit_o       (inhibit_o),
    .global_inhibit_o(global_inhibit_o),
    .fire_ok_o       (fire_ok_o)
);

// File: tb/trig_inhibit_regs_test.sv
// Bench for trig_inhibit_regs: directed corners plus seeded random writes,
// compared against a register model held in the bench.
module trig_inhibit_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] inhibit_o;
    logic        global_inhibit_o;
    logic [63:0] fire_ok_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] m_grp [16];
    logic [15:0] m_glb;

    always #5 clk = ~clk;

    trig_inhibit_regs uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .inhibit_o       (inhibit_o),
        .global_inhibit_o(global_inhibit_o),
        .fire_ok_o       (fire_ok_o)
    );

    // Expected read value per R1, R4, R5, R8.
    function automatic logic [15:0] exp_read(input logic [7:0] a);
        if (a == 8'h40) return m_glb;
        if (a >= 8'h10 && a <= 8'h2E && a[0] == 1'b0) return m_grp[(a - 8'h10) >> 1];
        return 16'h0000;
    endfunction

    // Expected inhibit lines per R1.
    function automatic logic [63:0] exp_inh();
        logic [63:0] v;
        for (int k = 0; k < 16; k++) v[k*4 +: 4] = m_grp[k][3:0];
        return v;
    endfunction

    // Expected permit lines per R6.
    function automatic logic [63:0] exp_fire();
        return m_glb[0] ? 64'h0 : ~exp_inh();
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Single write, then model update; lines checked one cycle later.
    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (exp_read(a) != 16'h0 || a == 8'h40 ||
            (a >= 8'h10 && a <= 8'h2E && a[0] == 1'b0)) begin
            if (a == 8'h40) m_glb = d;
            else if (a >= 8'h10 && a <= 8'h2E && a[0] == 1'b0) m_grp[(a - 8'h10) >> 1] = d;
        end
    endtask

    task automatic check_read(input string req, input logic [7:0] a);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(req, 64'(bus_rdata), 64'(exp_read(a)));
    endtask

    task automatic check_lines(input string req);
        chk({req, " inhibit_o"}, inhibit_o, exp_inh());
        chk({req, " global"}, 64'(global_inhibit_o), 64'(m_glb[0]));
        chk({"R6 fire_ok_o via ", req}, fire_ok_o, exp_fire());
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_1a7e);
        for (int k = 0; k < 16; k++) m_grp[k] = 16'h000F;
        m_glb = 16'h0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset image on lines; R8: full sweep of all addresses.
        check_lines("R7");
        chk("R7 fire_ok zero", fire_ok_o, 64'h0);
        for (int a = 0; a < 256; a++) check_read("R7/R8 sweep", 8'(a));

        // R9: idle cycles leave everything in place.
        repeat (5) @(negedge clk);
        check_lines("R9");

        // R1/R2: walk a single cleared lane per group, globally enabled.
        do_write(8'h40, 16'h0000);
        check_lines("R5");
        for (int k = 0; k < 16; k++) begin
            do_write(8'(8'h10 + 2*k), 16'h000E);
            check_lines("R1/R2 walk");
        end
        chk("R1 group0 lane0 permit", 64'(fire_ok_o[0]), 64'd1);
        chk("R1 group15 lane1 inhibit", 64'(inhibit_o[61]), 64'd1);

        // R3: upper bits stored but silent.
        do_write(8'h16, 16'hABC5);
        check_read("R3 readback", 8'h16);
        check_lines("R3");

        // R5: upper global bits stored, bit 0 governs permits.
        do_write(8'h40, 16'hFFFE);
        check_read("R5 readback", 8'h40);
        check_lines("R5 clear");
        do_write(8'h40, 16'h0001);
        check_lines("R5 set");
        chk("R6 global blocks all", fire_ok_o, 64'h0);

        // R8: writes in the gaps and beyond change nothing.
        do_write(8'h11, 16'hFFFF);
        do_write(8'h2F, 16'h0000);
        do_write(8'hFF, 16'h1234);
        check_lines("R8 unmapped write");
        for (int k = 0; k < 16; k++) check_read("R8 regs untouched", 8'(8'h10 + 2*k));

        // Random mix of mapped and unmapped writes with random data.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            if (pick < 6) a = 8'(8'h10 + 2*$urandom_range(0, 15));
            else if (pick < 8) a = 8'h40;
            else a = 8'($urandom_range(0, 255));
            do_write(a, 16'($urandom));
            check_lines("R2 random");
            check_read("R4 random", 8'($urandom_range(0, 255)));
            check_read("R4 written", a);
        end

        // R9: long idle with random addresses, nothing moves.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check_read("R9 idle read", 8'($urandom_range(0, 255)));
        end
        check_lines("R9 final");

        // R7: reset mid-run restores the reset image.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 16; k++) m_grp[k] = 16'h000F;
        m_glb = 16'h0001;
        check_lines("R7 re-reset");
        check_read("R7 re-reset read", 8'h2E);

        done = 1'b1;
        finish_run();
    end
endmodule